// File: doc/BRIEF.md
# Retirement Progress Watchdog

This block watches the in-order retirement port of an out-of-order core and raises a fatal internal timeout when work is waiting but nothing retires for a programmable number of cycles. A retirement strobe vector carries one bit per retirement lane. Any set bit in a cycle counts as progress and restarts the interval. The interval counter advances only while the core reports at least one instruction waiting to retire, so an idle core never trips the watchdog.

Progress stops when the oldest instruction cannot retire. That happens when it is a read that has not completed, whether from memory, I/O, memory-mapped I/O or configuration space. It also happens when it is a posted write held up by downstream back-pressure. In both cases the core sees pending work with no retirement, and the timer runs. On expiry the block drives an active-low catastrophic-error pin. When machine-check logging is enabled, it also writes a fixed timeout record into a 64-bit machine-check status register. The pin and the record stay set until software pulses a clear.

Top module: `retire_watchdog`

## Requirements
- R1: Out of reset, `cat_err_n` is 1 and `mc_status` is all zeros.
- R2: A cycle in which any bit of `retire_vld` is set, one or several, returns the interval count to zero.
- R3: If `work_pend` is 1 and no retirement occurs for T consecutive cycles since the last restart (T is the captured threshold), then `cat_err_n` is 0 after the clock edge that ends the T-th cycle. A stalled read and a back-pressured write both appear as this pattern.
- R4: A retirement in the T-th stalled cycle prevents the timeout, and the count restarts.
- R5: With `mc_log_en` = 1, a timeout writes `mc_status` = 64'h8000_0040_0000_0400. This sets the error code 0x400 in bits [15:0], bit 38 for the bus-initialisation timeout, and bit 63 as the valid flag.
- R6: With `mc_log_en` = 0, a timeout leaves `mc_status` unchanged but still drives `cat_err_n` to 0.
- R7: Cycles with `work_pend` = 0 neither advance nor reset the count. An idle core never times out.
- R8: `cat_err_n` = 0 and a valid `mc_status` entry hold until a clear. Later expiries do not change a valid entry.
- R9: A `sw_clear` pulse with no expiry in the same cycle returns `cat_err_n` to 1 and `mc_status` to zero on the next edge.
- R10: If an expiry and `sw_clear` occur in the same cycle, the expiry wins: `cat_err_n` is 0 and, with logging enabled, the entry is written.
- R11: `thresh` is captured only at clock edges where the count is zero (reset, restart, expiry or not yet advanced). Changing it mid-interval does not alter the current interval.
- R12: A captured threshold of zero disables the watchdog.
- R13: After an expiry the count restarts from zero, so a continued stall expires again after another T cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_vld | input | LANES | One bit per retirement lane retiring this cycle |
| work_pend | input | 1 | At least one instruction waits to retire |
| mc_log_en | input | 1 | Machine-check logging enable |
| thresh | input | CNT_W | Timeout interval in cycles; 0 disables |
| sw_clear | input | 1 | Software clear pulse for pin and status |
| cat_err_n | output | 1 | Active-low catastrophic internal error |
| mc_status | output | 64 | Machine-check status record |

## Verification
Expiry is found combinationally from the registered count during the T-th stalled cycle. The pin and the status record are both registered, so each reacts one edge after the stimulus that caused it: a clear, an expiry or a retirement on the deciding cycle. The bench drives inputs on the falling edge and samples outputs on the next falling edge, half a cycle after the rising edge that updates them. A behavioural model advances on the same rising edge and is compared on every cycle. Directed checks count stalled cycles from a retirement so they land exactly on the T-th edge, or one cycle before it.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  localparam int unsigned MC_W        = 64;
  localparam int unsigned CODE_W      = 16;
  localparam logic [CODE_W-1:0] TMO_CODE = 16'h0400;
  localparam int unsigned BINIT_BIT   = 38;
  localparam int unsigned VALID_BIT   = 63;

  function automatic logic [MC_W-1:0] tmo_record();
    logic [MC_W-1:0] r;
    r = '0;
    r[CODE_W-1:0] = TMO_CODE;
    r[BINIT_BIT]  = 1'b1;
    r[VALID_BIT]  = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/rwd_timer.sv
module rwd_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] retire_vld,
  input  logic             work_pend,
  input  logic [CNT_W-1:0] thresh,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thr_q;
  logic             thr_en;
  logic             any_ret, armed, hit;

  always_comb begin
    any_ret = |retire_vld;
    armed   = (thr_q != '0);
    hit     = armed && work_pend && !any_ret && (cnt_q == thr_q - 1'b1);
    if (any_ret || hit || !armed) cnt_d = '0;
    else if (work_pend)           cnt_d = cnt_q + 1'b1;
    else                          cnt_d = cnt_q;
    thr_en  = (cnt_d == '0);
    expire  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_en) thr_q <= thresh;
  end
endmodule

// File: rtl/rwd_logger.sv
module rwd_logger
  import rwd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expire,
  input  logic            mc_log_en,
  input  logic            sw_clear,
  output logic            err_flag,
  output logic [MC_W-1:0] status
);
  logic            err_q, err_d;
  logic [MC_W-1:0] st_q, st_d;
  logic [MC_W-1:0] st_base;

  always_comb begin
    err_d   = (err_q && !sw_clear) || expire;
    st_base = sw_clear ? '0 : st_q;
    if (expire && mc_log_en && !st_base[VALID_BIT]) st_d = tmo_record();
    else                                           st_d = st_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign err_flag = err_q;
  assign status   = st_q;
endmodule

// File: rtl/retire_watchdog.sv
module retire_watchdog
  import rwd_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] retire_vld,
  input  logic             work_pend,
  input  logic             mc_log_en,
  input  logic [CNT_W-1:0] thresh,
  input  logic             sw_clear,
  output logic             cat_err_n,
  output logic [MC_W-1:0]  mc_status
);
  logic expire;
  logic err_flag;

  rwd_timer #(.CNT_W(CNT_W), .LANES(LANES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_vld (retire_vld),
    .work_pend  (work_pend),
    .thresh     (thresh),
    .expire     (expire)
  );

  rwd_logger u_logger (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .mc_log_en (mc_log_en),
    .sw_clear  (sw_clear),
    .err_flag  (err_flag),
    .status    (mc_status)
  );

  assign cat_err_n = !err_flag;
endmodule

// File: rtl/retire_watchdog_chk.sv
module retire_watchdog_chk
  import rwd_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] retire_vld,
  input logic             work_pend,
  input logic             mc_log_en,
  input logic [CNT_W-1:0] thresh,
  input logic             sw_clear,
  input logic             cat_err_n,
  input logic [MC_W-1:0]  mc_status
);
  AST_RETIRE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (|retire_vld) && cat_err_n |=> cat_err_n); // R4
  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !work_pend && cat_err_n |=> cat_err_n); // R7
  AST_PIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cat_err_n && !sw_clear |=> !cat_err_n); // R8
  AST_ENTRY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mc_status[VALID_BIT] && !sw_clear |=> $stable(mc_status)); // R8
  AST_RECORD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mc_status[VALID_BIT] |-> (mc_status[CODE_W-1:0] == TMO_CODE) && mc_status[BINIT_BIT]); // R5
  AST_NO_LOG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_log_en && !mc_status[VALID_BIT] |=> !mc_status[VALID_BIT]); // R6
  AST_LOG_WITH_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_status[VALID_BIT]) |-> !cat_err_n); // R5
  AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0) && (|retire_vld) && cat_err_n |=> cat_err_n); // R12
endmodule

bind retire_watchdog retire_watchdog_chk #(.CNT_W(CNT_W), .LANES(LANES)) u_chk (.*);

// File: tb/retire_watchdog_tb.sv
module retire_watchdog_tb;
  localparam int CNT_W = 16;
  localparam int LANES = 2;
  localparam logic [63:0] REC = 64'h8000_0040_0000_0400;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] retire_vld;
  logic             work_pend, mc_log_en, sw_clear;
  logic [CNT_W-1:0] thresh;
  logic             cat_err_n;
  logic [63:0]      mc_status;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  retire_watchdog #(.CNT_W(CNT_W), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .work_pend(work_pend),
    .mc_log_en(mc_log_en), .thresh(thresh), .sw_clear(sw_clear),
    .cat_err_n(cat_err_n), .mc_status(mc_status)
  );

  // behavioural reference
  int          m_cnt, m_thr;
  bit          m_err;
  logic [63:0] m_st;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_thr <= 0; m_err <= 0; m_st <= '0;
    end else begin
      bit ex;
      int nc;
      logic [63:0] s;
      ex = (m_thr > 0) && work_pend && (retire_vld == 0) && (m_cnt + 1 >= m_thr);
      if (retire_vld != 0 || ex || m_thr == 0) nc = 0;
      else nc = work_pend ? m_cnt + 1 : m_cnt;
      if (nc == 0) m_thr <= int'(thresh);
      m_cnt <= nc;
      m_err <= ex || (m_err && !sw_clear);
      s = sw_clear ? 64'h0 : m_st;
      if (ex && mc_log_en && !s[63]) s = REC;
      m_st <= s;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cat_err_n == !m_err, "R3 model pin", 64'(cat_err_n), 64'(!m_err));
      check(mc_status == m_st, "R5 model status", mc_status, m_st);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input logic [LANES-1:0] r, input logic p, input logic c);
    retire_vld = r; work_pend = p; sw_clear = c;
    @(negedge clk);
  endtask

  task automatic stall(input int n);
    for (int i = 0; i < n; i++) cyc('0, 1'b1, 1'b0);
  endtask

  task automatic pin(input logic exp, input string req);
    check(cat_err_n === exp, req, 64'(cat_err_n), 64'(exp));
  endtask

  task automatic st(input logic [63:0] exp, input string req);
    check(mc_status === exp, req, mc_status, exp);
  endtask

  initial begin
    rst_n = 1'b0; retire_vld = '0; work_pend = 1'b0; mc_log_en = 1'b1;
    sw_clear = 1'b0; thresh = 16'd4;
    repeat (3) @(negedge clk);
    pin(1'b1, "R1 reset pin"); st(64'h0, "R1 reset status");
    rst_n = 1'b1;
    // R4 and R2: dual-lane retire on the 4th stalled cycle
    cyc(2'b01, 1, 0); stall(3);
    pin(1'b1, "R3 not yet expired");
    cyc(2'b11, 1, 0);
    pin(1'b1, "R4 retire on expiry cycle");
    stall(3); pin(1'b1, "R2 restart by multi-lane retire");
    stall(1); pin(1'b0, "R3 expiry after T stalls");
    st(REC, "R5 logged record");
    // R8 stickiness and R13 back-to-back
    stall(4); pin(1'b0, "R8 pin sticky"); st(REC, "R8 entry kept");
    cyc('0, 0, 1); pin(1'b1, "R9 clear pin"); st(64'h0, "R9 clear status");
    stall(4); pin(1'b0, "R13 second expiry"); st(REC, "R13 second record");
    cyc('0, 0, 1);
    // R10 clear collides with expiry
    cyc(2'b10, 1, 0); stall(3); cyc('0, 1, 1);
    pin(1'b0, "R10 expiry beats clear"); st(REC, "R10 record written");
    cyc('0, 0, 1);
    // R7 idle freezes count
    cyc(2'b01, 1, 0); stall(2);
    for (int i = 0; i < 20; i++) cyc('0, 0, 0);
    pin(1'b1, "R7 idle no timeout");
    stall(2); pin(1'b0, "R7 count resumed");
    cyc('0, 0, 1);
    // R6 logging disabled
    mc_log_en = 1'b0;
    cyc(2'b01, 1, 0); stall(4);
    pin(1'b0, "R6 pin without log"); st(64'h0, "R6 no record");
    cyc('0, 0, 1); mc_log_en = 1'b1;
    // R11 threshold capture
    cyc(2'b01, 1, 0); thresh = 16'd10; stall(4);
    pin(1'b0, "R11 old threshold kept");
    cyc('0, 0, 1); cyc(2'b01, 1, 0); stall(9);
    pin(1'b1, "R11 new threshold not yet");
    stall(1); pin(1'b0, "R11 new threshold expiry");
    cyc('0, 0, 1);
    // R12 zero threshold
    thresh = 16'd0; cyc('0, 0, 0); cyc(2'b01, 1, 0); stall(50);
    pin(1'b1, "R12 disabled"); st(64'h0, "R12 no record");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule